// File: doc/BRIEF.md
# Logical and Sign-Preserving Arithmetic Shifter

This block shifts a data word by a variable distance in either direction. A select input chooses between two kinds of shift. A logical shift moves every bit of the word. An arithmetic shift treats the word as a signed two's-complement integer and never moves the sign bit. Together with the shifted word, the block reports the last bit that was pushed out of the word.

All of the shifting logic is combinational. One register stage sits at the output and carries a valid flag, so a result appears on the clock edge after the operands are presented with `in_valid`. Operands may arrive on every cycle. The output register changes only when a new operand is accepted.

Top module: `shift_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid`, `out_data` and `out_spill` are all 0.
- R2: `out_valid` equals the value `in_valid` had one cycle earlier. `out_data` and `out_spill` load only on a cycle with `in_valid` high and hold their values otherwise.
- R3: A shift amount of 0 returns the input word unchanged and gives `out_spill` = 0, in every mode.
- R4: Logical left (`in_dir`=0, `in_arith`=0) by n: output bit i is input bit i-n for i ≥ n and 0 below that. `out_spill` is input bit WIDTH-n.
- R5: Logical right (`in_dir`=1, `in_arith`=0) by n: output bit i is input bit i+n, and the top n bits are 0. `out_spill` is input bit n-1.
- R6: Arithmetic right (`in_dir`=1, `in_arith`=1) by n: output bit i is input bit i+n, and the top n bits all copy the input sign bit (bit WIDTH-1). `out_spill` is input bit n-1.
- R7: Arithmetic left (`in_dir`=0, `in_arith`=1) by n: output bit WIDTH-1 keeps the input sign bit. Output bits WIDTH-2..0 are input bits WIDTH-2..0 shifted up by n, with zeros entering at bit 0. Bits that move above position WIDTH-2 are discarded. `out_spill` is input bit WIDTH-1-n.
- R8: The largest legal amount, WIDTH-1, follows R4 to R7 exactly. A logical shift then leaves a single input bit, an arithmetic right shift gives a word that is all sign, and an arithmetic left shift gives the sign bit above zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present this cycle |
| in_data | input | WIDTH | Word to shift |
| in_amt | input | $clog2(WIDTH) | Shift distance, 0 to WIDTH-1 |
| in_dir | input | 1 | 0 = toward the MSB, 1 = toward the LSB |
| in_arith | input | 1 | 0 = logical, 1 = arithmetic (sign kept) |
| out_valid | output | 1 | Result registered this cycle |
| out_data | output | WIDTH | Shifted word |
| out_spill | output | 1 | Last bit discarded, 0 when the amount is 0 |

## Verification
The bench builds the shifter with WIDTH = 8. At that width every input word, every shift amount and every one of the four modes can be applied, which gives 8192 operand sets. Each set is compared against a bit-by-bit model written from the requirements. The sweep covers both sign values, amount 0, amount WIDTH-1, and the bit-position edges of the spill rule, without relying on chosen samples.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } shift_dir_e;

  typedef enum logic {
    KIND_LOGIC = 1'b0,
    KIND_ARITH = 1'b1
  } shift_kind_e;
endpackage

// File: rtl/shift_prep.sv
module shift_prep
  import shift_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] data,
  input  shift_dir_e       dir,
  input  shift_kind_e      kind,
  output logic [WIDTH:0]   operand,
  output logic             fill
);
  logic [WIDTH-1:0] base;
  logic [WIDTH-1:0] oriented;

  // An arithmetic left shift works on the bits below the sign.
  // They are lifted one place so that a plain left shift covers them.
  always_comb begin
    if (kind == KIND_ARITH && dir == DIR_LEFT)
      base = {data[WIDTH-2:0], 1'b0};
    else
      base = data;
  end

  // Left shifts are mirrored so that a single right-shifting barrel serves both directions.
  always_comb begin
    for (int i = 0; i < WIDTH; i++)
      oriented[i] = (dir == DIR_LEFT) ? base[WIDTH-1-i] : base[i];
  end

  // The extra guard bit at the bottom collects the last bit pushed out.
  assign operand = {oriented, 1'b0};
  assign fill    = (kind == KIND_ARITH && dir == DIR_RIGHT) ? data[WIDTH-1] : 1'b0;
endmodule

// File: rtl/shift_barrel.sv
module shift_barrel #(
  parameter int WIDTH = 16,
  parameter int AMT_W = 4
) (
  input  logic [WIDTH:0]   din,
  input  logic [AMT_W-1:0] amt,
  input  logic             fill,
  output logic [WIDTH:0]   dout
);
  logic [WIDTH:0] stage [0:AMT_W];

  assign stage[0] = din;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage[s+1] = amt[s] ? {{SH{fill}}, stage[s][WIDTH:SH]} : stage[s];
  end

  assign dout = stage[AMT_W];

  // R3
  always_comb begin
    if (amt == '0) begin
      barrel_zero_pass_chk: assert (dout == din);
    end
  end
endmodule

// File: rtl/shift_finish.sv
module shift_finish
  import shift_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH:0]   shifted,
  input  logic             sign_in,
  input  shift_dir_e       dir,
  input  shift_kind_e      kind,
  output logic [WIDTH-1:0] result,
  output logic             spill
);
  logic [WIDTH-1:0] body;
  logic [WIDTH-1:0] restored;

  assign body  = shifted[WIDTH:1];
  assign spill = shifted[0];

  // Undo the mirror that was applied for left shifts.
  always_comb begin
    for (int i = 0; i < WIDTH; i++)
      restored[i] = (dir == DIR_LEFT) ? body[WIDTH-1-i] : body[i];
  end

  // Put the original sign back above the shifted lower bits.
  always_comb begin
    if (kind == KIND_ARITH && dir == DIR_LEFT)
      result = {sign_in, restored[WIDTH-1:1]};
    else
      result = restored;
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter  int WIDTH = 16,
  localparam int AMT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  input  logic [AMT_W-1:0] in_amt,
  input  logic             in_dir,
  input  logic             in_arith,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic             out_spill
);
  shift_dir_e       dir;
  shift_kind_e      kind;
  logic [WIDTH:0]   operand;
  logic [WIDTH:0]   shifted;
  logic             fill;
  logic [WIDTH-1:0] result;
  logic             spill;

  assign dir  = shift_dir_e'(in_dir);
  assign kind = shift_kind_e'(in_arith);

  shift_prep #(.WIDTH(WIDTH)) u_prep (
    .data    (in_data),
    .dir     (dir),
    .kind    (kind),
    .operand (operand),
    .fill    (fill)
  );

  shift_barrel #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_barrel (
    .din  (operand),
    .amt  (in_amt),
    .fill (fill),
    .dout (shifted)
  );

  shift_finish #(.WIDTH(WIDTH)) u_finish (
    .shifted (shifted),
    .sign_in (in_data[WIDTH-1]),
    .dir     (dir),
    .kind    (kind),
    .result  (result),
    .spill   (spill)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_spill <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= result;
        out_spill <= spill;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_spill)));

  // R3
  zero_amount_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_amt == '0) |=> (out_data == $past(in_data) && !out_spill));

  // R6 R7
  sign_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_arith) |=> (out_data[WIDTH-1] == $past(in_data[WIDTH-1])));

  // R5
  logic_right_top_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_arith && in_dir && in_amt != '0) |=> !out_data[WIDTH-1]);

  // R4 R7
  left_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_dir && in_amt != '0) |=> !out_data[0]);
endmodule

// File: tb/shift_unit_test.sv
module shift_unit_test;
  localparam int W  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic [AW-1:0] in_amt = '0;
  logic          in_dir = 1'b0;
  logic          in_arith = 1'b0;
  logic          out_valid;
  logic [W-1:0]  out_data;
  logic          out_spill;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shift_unit #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_amt(in_amt), .in_dir(in_dir), .in_arith(in_arith),
    .out_valid(out_valid), .out_data(out_data), .out_spill(out_spill)
  );

  // Bit-by-bit model taken straight from R3 to R7.
  function automatic void model(input logic [W-1:0] d, input int n, input bit right,
                                input bit ar, output logic [W-1:0] r, output logic s);
    r = '0;
    s = 1'b0;
    if (n == 0) begin
      r = d;
      return;
    end
    if (!right && !ar) begin
      for (int i = 0; i < W; i++) r[i] = (i >= n) ? d[i-n] : 1'b0;
      s = d[W-n];
    end else if (right && !ar) begin
      for (int i = 0; i < W; i++) r[i] = (i + n < W) ? d[i+n] : 1'b0;
      s = d[n-1];
    end else if (right && ar) begin
      for (int i = 0; i < W; i++) r[i] = (i + n < W) ? d[i+n] : d[W-1];
      s = d[n-1];
    end else begin
      for (int i = 0; i < W-1; i++) r[i] = (i >= n) ? d[i-n] : 1'b0;
      r[W-1] = d[W-1];
      s = d[W-1-n];
    end
  endfunction

  task automatic check(input string req, input logic v, input logic [W-1:0] d,
                       input logic s, input logic ev, input logic [W-1:0] ed, input logic es);
    checks++;
    if (v !== ev || d !== ed || s !== es) begin
      errors++;
      $display("FAIL %s: got valid=%b data=%h spill=%b, expected valid=%b data=%h spill=%b",
               req, v, d, s, ev, ed, es);
    end
  endtask

  task automatic sweep(input string req, input bit right, input bit ar, input int n_lo, input int n_hi);
    logic [W-1:0] er;
    logic es;
    @(negedge clk);
    for (int dv = 0; dv < (1 << W); dv++) begin
      for (int n = n_lo; n <= n_hi; n++) begin
        in_valid = 1'b1;
        in_data  = W'(dv);
        in_amt   = AW'(n);
        in_dir   = right;
        in_arith = ar;
        model(W'(dv), n, right, ar, er, es);
        @(negedge clk);
        check(req, out_valid, out_data, out_spill, 1'b1, er, es);
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    in_data = 8'hA5;
    in_amt = 3'd2;
    repeat (2) @(negedge clk);
    check("R1 during reset", out_valid, out_data, out_spill, 1'b0, '0, 1'b0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", out_valid, out_data, out_spill, 1'b0, '0, 1'b0);
  endtask

  task automatic t_zero_amount();
    for (int m = 0; m < 4; m++) sweep("R3", m[1], m[0], 0, 0);
  endtask

  task automatic t_logic_left();  sweep("R4", 1'b0, 1'b0, 1, W-1); endtask
  task automatic t_logic_right(); sweep("R5", 1'b1, 1'b0, 1, W-1); endtask
  task automatic t_arith_right(); sweep("R6", 1'b1, 1'b1, 1, W-1); endtask
  task automatic t_arith_left();  sweep("R7", 1'b0, 1'b1, 1, W-1); endtask

  task automatic t_max_amount();
    for (int m = 0; m < 4; m++) sweep("R8", m[1], m[0], W-1, W-1);
  endtask

  task automatic t_hold();
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'b1100_1011;
    in_amt   = 3'd3;
    in_dir   = 1'b1;
    in_arith = 1'b1;
    @(negedge clk);
    check("R2 load", out_valid, out_data, out_spill, 1'b1, 8'b1111_1001, 1'b0);
    in_valid = 1'b0;
    in_data  = 8'h0F;
    in_amt   = 3'd1;
    in_dir   = 1'b0;
    in_arith = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R2 hold", out_valid, out_data, out_spill, 1'b0, 8'b1111_1001, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_zero_amount();
    t_logic_left();
    t_logic_right();
    t_arith_right();
    t_arith_left();
    t_max_amount();
    t_hold();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion within 150000 cycles");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule